// File: doc/BRIEF.md
# Grouped floating-point vector clamp

This block clamps every lane of a group of two or four destination vector registers to a per-lane window. Each lane first takes the number-preferring maximum of its current value and a lower-bound vector. The lane then takes the number-preferring minimum of that partial result and an upper-bound vector. One lower-bound vector and one upper-bound vector serve the whole group. The lane at index i of every destination register uses bound lane i.

A sequencer presents the raw 32-bit instruction word, the two feature enables, the destination group and the two bound vectors, and pulses `start`. One cycle later the block returns the updated group with a `done` pulse. With the result it reports an illegal-encoding flag and an invalid-operation flag. The order of lane values is decided only from sign-magnitude comparisons, so the block has no adder or subtractor. Lanes are bfloat16, half, single or double precision, chosen by the size field of the instruction.

Top module: `vec_fclamp_group`

## Requirements
- R1: After reset `done`, `illegal` and `invalid` are 0 and `res` is all zeros. `done` is 1 exactly in the cycle after a cycle with `start` high. Without `start`, `res` and the flags hold their values.
- R2: For a legal instruction, each active lane becomes min(max(d, lo), hi), with the max step applied first. So when lo is above hi, the lane returns hi.
- R3: Size field `insn[23:22]` selects the lane format: 0 is bfloat16 (8-bit exponent, 7-bit fraction), 1 is half (5/10), 2 is single (8/23), 3 is double (11/52). Lanes are packed from bit 0 upward.
- R4: An instruction is legal only if all of these hold: `insn[31:24]` is 8'hC1, `insn[21]` is 1, `insn[0]` is 0, and `insn[15:10]` is either 6'b110000 (two registers) or 6'b110010 (four registers). The four-register form also needs `insn[1]` to be 0.
- R5: Size 0 is legal only when `feat_bf16` is 1. Sizes 1 to 3 are legal only when `feat_base` is 1.
- R6: For an illegal instruction, `done` still pulses, `illegal` is 1, `invalid` is 0 and `res` equals `dst` unchanged.
- R7: In the two-register form, registers 2 and 3 of `res` equal those of `dst`, and signalling NaNs in them do not set `invalid`.
- R8: Bound lane i applies to lane i of every register in the group.
- R9: When exactly one operand of a max or min step is a NaN, the step returns the other operand. When both are NaN, it returns the default NaN: sign 0, exponent all ones, top fraction bit 1, all other bits 0.
- R10: `invalid` is 1 when any active lane of d, lo or hi is a signalling NaN (exponent all ones, top fraction bit 0, fraction nonzero). For result selection, a signalling NaN is treated like a quiet NaN.
- R11: Between +0 and -0, max returns +0 and min returns -0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin one clamp operation |
| insn | input | 32 | Raw instruction word |
| feat_base | input | 1 | Base feature enable for half, single and double |
| feat_bf16 | input | 1 | Feature enable for the bfloat16 form |
| dst | input | 4*VLEN | Destination group, register r at bits [r*VLEN +: VLEN] |
| lo_bnd | input | VLEN | Lower-bound vector |
| hi_bnd | input | VLEN | Upper-bound vector |
| res | output | 4*VLEN | Updated destination group |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Instruction was not accepted |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with VLEN = 128. That gives eight 16-bit, four 32-bit and two 64-bit lanes per register across a 512-bit group, so every lane format runs in both group sizes. The width is enough for lane-sharing of the bounds to show up as mismatches between registers. Random elements are biased toward signed zeros, infinities, quiet NaNs with payloads and signalling NaNs, so the NaN and zero rules are hit often. Random bit flips in the instruction word, together with dropped feature enables, exercise the decode paths.

// File: rtl/fclamp_pkg.sv
package fclamp_pkg;
  localparam int GRP_MAX = 4;
  localparam logic [7:0] OP_HI    = 8'hC1;
  localparam logic [5:0] OP_PAIR  = 6'b110000;
  localparam logic [5:0] OP_QUAD  = 6'b110010;

  typedef enum logic [1:0] {
    FMT_BF16   = 2'd0,
    FMT_HALF   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fc_fmt_e;
endpackage

// File: rtl/fclamp_decode.sv
module fclamp_decode
  import fclamp_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        feat_base,
  input  logic        feat_bf16,
  output logic        ok,
  output logic        quad,
  output fc_fmt_e     fmt
);
  logic enc_pair, enc_quad, enc_ok, feat_ok;

  always_comb begin
    fmt      = fc_fmt_e'(insn[23:22]);
    enc_pair = (insn[15:10] == OP_PAIR);
    enc_quad = (insn[15:10] == OP_QUAD) && !insn[1];
    enc_ok   = (insn[31:24] == OP_HI) && insn[21] && !insn[0] &&
               (enc_pair || enc_quad);
    feat_ok  = (fmt == FMT_BF16) ? feat_bf16 : feat_base;
    ok       = enc_ok && feat_ok;
    quad     = enc_quad;
  end
endmodule

// File: rtl/fclamp_lane.sv
module fclamp_lane #(
  parameter int W   = 16,
  parameter int EWA = 5,
  parameter int EWB = 5
) (
  input  logic         alt,
  input  logic [W-1:0] d,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] y,
  output logic         snan
);
  localparam int MA = W - 1 - EWA;
  localparam int MB = W - 1 - EWB;
  localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] SGN    = ONE << (W - 1);
  localparam logic [W-1:0] EXPM_A = ((ONE << EWA) - ONE) << MA;
  localparam logic [W-1:0] EXPM_B = ((ONE << EWB) - ONE) << MB;
  localparam logic [W-1:0] MANM_A = (ONE << MA) - ONE;
  localparam logic [W-1:0] MANM_B = (ONE << MB) - ONE;
  localparam logic [W-1:0] QBIT_A = ONE << (MA - 1);
  localparam logic [W-1:0] QBIT_B = ONE << (MB - 1);

  logic [W-1:0] expm, manm, qbit, dnan, t;
  logic         nd, nl, nh, nt;

  function automatic logic nan_of(input logic [W-1:0] x, input logic [W-1:0] em,
                                  input logic [W-1:0] mm);
    return ((x & em) == em) && ((x & mm) != '0);
  endfunction

  // ordered key: unsigned compare of keys equals numeric order, -0 below +0
  function automatic logic [W-1:0] okey(input logic [W-1:0] x);
    return x[W-1] ? ~x : (x | SGN);
  endfunction

  always_comb begin
    expm = alt ? EXPM_B : EXPM_A;
    manm = alt ? MANM_B : MANM_A;
    qbit = alt ? QBIT_B : QBIT_A;
    dnan = expm | qbit;
    nd   = nan_of(d, expm, manm);
    nl   = nan_of(lo, expm, manm);
    nh   = nan_of(hi, expm, manm);
    snan = (nd && ((d & qbit) == '0)) || (nl && ((lo & qbit) == '0)) ||
           (nh && ((hi & qbit) == '0));
    if (nd && nl)      t = dnan;
    else if (nd)       t = lo;
    else if (nl)       t = d;
    else               t = (okey(d) >= okey(lo)) ? d : lo;
    nt = nd && nl;
    if (nt && nh)      y = dnan;
    else if (nt)       y = hi;
    else if (nh)       y = t;
    else               y = (okey(t) <= okey(hi)) ? t : hi;
  end
endmodule

// File: rtl/vec_fclamp_group.sv
module vec_fclamp_group
  import fclamp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [31:0]             insn,
  input  logic                    feat_base,
  input  logic                    feat_bf16,
  input  logic [GRP_MAX*VLEN-1:0] dst,
  input  logic [VLEN-1:0]         lo_bnd,
  input  logic [VLEN-1:0]         hi_bnd,
  output logic [GRP_MAX*VLEN-1:0] res,
  output logic                    done,
  output logic                    illegal,
  output logic                    invalid
);
  localparam int GW  = GRP_MAX * VLEN;
  localparam int L16 = VLEN / 16;
  localparam int L32 = VLEN / 32;
  localparam int L64 = VLEN / 64;

  logic    dec_ok, dec_quad;
  fc_fmt_e dec_fmt;

  fclamp_decode u_dec (
    .insn      (insn),
    .feat_base (feat_base),
    .feat_bf16 (feat_bf16),
    .ok        (dec_ok),
    .quad      (dec_quad),
    .fmt       (dec_fmt)
  );

  logic [GW-1:0]          y16, y32, y64;
  logic [GRP_MAX*L16-1:0] sn16;
  logic [GRP_MAX*L32-1:0] sn32;
  logic [GRP_MAX*L64-1:0] sn64;
  logic                   is_bf;

  assign is_bf = (dec_fmt == FMT_BF16);

  for (genvar r = 0; r < GRP_MAX; r++) begin : g_reg
    for (genvar i = 0; i < L16; i++) begin : g_h
      fclamp_lane #(.W(16), .EWA(5), .EWB(8)) u_lane (
        .alt  (is_bf),
        .d    (dst[r*VLEN + i*16 +: 16]),
        .lo   (lo_bnd[i*16 +: 16]),
        .hi   (hi_bnd[i*16 +: 16]),
        .y    (y16[r*VLEN + i*16 +: 16]),
        .snan (sn16[r*L16 + i])
      );
    end
    for (genvar i = 0; i < L32; i++) begin : g_s
      fclamp_lane #(.W(32), .EWA(8), .EWB(8)) u_lane (
        .alt  (1'b0),
        .d    (dst[r*VLEN + i*32 +: 32]),
        .lo   (lo_bnd[i*32 +: 32]),
        .hi   (hi_bnd[i*32 +: 32]),
        .y    (y32[r*VLEN + i*32 +: 32]),
        .snan (sn32[r*L32 + i])
      );
    end
    for (genvar i = 0; i < L64; i++) begin : g_d
      fclamp_lane #(.W(64), .EWA(11), .EWB(11)) u_lane (
        .alt  (1'b0),
        .d    (dst[r*VLEN + i*64 +: 64]),
        .lo   (lo_bnd[i*64 +: 64]),
        .hi   (hi_bnd[i*64 +: 64]),
        .y    (y64[r*VLEN + i*64 +: 64]),
        .snan (sn64[r*L64 + i])
      );
    end
  end

  logic [GW-1:0] res_q, res_d;
  logic          done_q, done_d, ill_q, ill_d, inv_q, inv_d;
  logic          act, sn_r;

  always_comb begin
    res_d  = res_q;
    ill_d  = ill_q;
    inv_d  = inv_q;
    done_d = start;
    act    = 1'b0;
    sn_r   = 1'b0;
    if (start) begin
      if (!dec_ok) begin
        res_d = dst;
        ill_d = 1'b1;
        inv_d = 1'b0;
      end else begin
        ill_d = 1'b0;
        inv_d = 1'b0;
        for (int r = 0; r < GRP_MAX; r++) begin
          act = (r < 2) || dec_quad;
          case (dec_fmt)
            FMT_SINGLE: sn_r = |sn32[r*L32 +: L32];
            FMT_DOUBLE: sn_r = |sn64[r*L64 +: L64];
            default:    sn_r = |sn16[r*L16 +: L16];
          endcase
          if (act) begin
            case (dec_fmt)
              FMT_SINGLE: res_d[r*VLEN +: VLEN] = y32[r*VLEN +: VLEN];
              FMT_DOUBLE: res_d[r*VLEN +: VLEN] = y64[r*VLEN +: VLEN];
              default:    res_d[r*VLEN +: VLEN] = y16[r*VLEN +: VLEN];
            endcase
            inv_d = inv_d | sn_r;
          end else begin
            res_d[r*VLEN +: VLEN] = dst[r*VLEN +: VLEN];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start) begin
        res_q <= res_d;
        ill_q <= ill_d;
        inv_q <= inv_d;
      end
    end
  end

  assign res     = res_q;
  assign done    = done_q;
  assign illegal = ill_q;
  assign invalid = inv_q;
endmodule

// File: rtl/fclamp_chk.sv
module fclamp_chk
  import fclamp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [31:0]             insn,
  input logic [GRP_MAX*VLEN-1:0] dst,
  input logic [GRP_MAX*VLEN-1:0] res,
  input logic                    done,
  input logic                    illegal,
  input logic                    invalid
);
  // R1
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R1
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R1
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(res) && $stable(invalid) && $stable(illegal));
  // R6
  illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (res == $past(dst)) && !invalid);
  // R7
  pair_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !$past(insn[11])) |->
      res[GRP_MAX*VLEN-1:2*VLEN] == $past(dst[GRP_MAX*VLEN-1:2*VLEN]));
endmodule

bind vec_fclamp_group fclamp_chk #(.VLEN(VLEN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .insn    (insn),
  .dst     (dst),
  .res     (res),
  .done    (done),
  .illegal (illegal),
  .invalid (invalid)
);

// File: tb/vec_fclamp_group_tb.sv
`timescale 1ns/1ps
module vec_fclamp_group_tb;
  localparam int VL = 128;
  localparam int NR = 4;
  localparam int GW = NR * VL;

  logic          clk, rst_n, start, feat_base, feat_bf16;
  logic [31:0]   insn;
  logic [GW-1:0] dst, res;
  logic [VL-1:0] lo_bnd, hi_bnd;
  logic          done, illegal, invalid;
  int            n_chk, n_bad;
  bit            finished;

  vec_fclamp_group #(.VLEN(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .feat_base(feat_base), .feat_bf16(feat_bf16), .dst(dst),
    .lo_bnd(lo_bnd), .hi_bnd(hi_bnd), .res(res), .done(done),
    .illegal(illegal), .invalid(invalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [GW-1:0] act, input logic [GW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int fw(input int f);
    return (f >= 2) ? ((f == 2) ? 32 : 64) : 16;
  endfunction
  function automatic int few(input int f);
    case (f)
      0: return 8;
      1: return 5;
      2: return 8;
      default: return 11;
    endcase
  endfunction

  function automatic logic [63:0] emask(input int ew);
    return (64'd1 << ew) - 64'd1;
  endfunction
  function automatic bit r_nan(input logic [63:0] x, input int w, input int ew);
    return (((x >> (w - 1 - ew)) & emask(ew)) == emask(ew)) &&
           ((x & ((64'd1 << (w - 1 - ew)) - 64'd1)) != 64'd0);
  endfunction
  function automatic bit r_snan(input logic [63:0] x, input int w, input int ew);
    return r_nan(x, w, ew) && !x[w - 2 - ew];
  endfunction
  function automatic logic [63:0] r_dnan(input int w, input int ew);
    return (emask(ew) << (w - 1 - ew)) | (64'd1 << (w - 2 - ew));
  endfunction
  // a strictly above b, -0 counted below +0
  function automatic bit r_gt(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [63:0] mm, ma, mb;
    bit sa, sb;
    mm = (w == 64) ? 64'h7FFF_FFFF_FFFF_FFFF : ((64'd1 << (w - 1)) - 64'd1);
    sa = a[w-1]; sb = b[w-1];
    ma = a & mm; mb = b & mm;
    if (sa != sb) return !sa;
    if (!sa) return ma > mb;
    return ma < mb;
  endfunction
  function automatic logic [63:0] r_max(input logic [63:0] a, input logic [63:0] b, input int w, input int ew);
    bit na, nb;
    na = r_nan(a, w, ew); nb = r_nan(b, w, ew);
    if (na && nb) return r_dnan(w, ew);
    if (na) return b;
    if (nb) return a;
    return r_gt(b, a, w) ? b : a;
  endfunction
  function automatic logic [63:0] r_min(input logic [63:0] a, input logic [63:0] b, input int w, input int ew);
    bit na, nb;
    na = r_nan(a, w, ew); nb = r_nan(b, w, ew);
    if (na && nb) return r_dnan(w, ew);
    if (na) return b;
    if (nb) return a;
    return r_gt(a, b, w) ? b : a;
  endfunction

  function automatic logic [31:0] mk_insn(input int f, input bit quad);
    logic [31:0] x;
    x = {8'hC1, 2'(f), 1'b1, 5'($urandom), (quad ? 6'b110010 : 6'b110000),
         5'($urandom), 5'($urandom)};
    x[0] = 1'b0;
    if (quad) x[1] = 1'b0;
    return x;
  endfunction

  function automatic logic [63:0] gen_el(input int w, input int ew);
    logic [63:0] v;
    logic [63:0] wm;
    wm = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    v = {$urandom, $urandom};
    case ($urandom % 10)
      0: v = 64'd0;
      1: v = 64'd1 << (w - 1);
      2: v = (v & (64'd1 << (w - 1))) | r_dnan(w, ew) | (v & 64'd3);
      3: v = (emask(ew) << (w - 1 - ew)) | 64'd1 | (v & 64'd4);
      4: v = (v & (64'd1 << (w - 1))) | (emask(ew) << (w - 1 - ew));
      5: v = v & ((64'd1 << (w - 4)) - 64'd1);
      default: v = v;
    endcase
    return v & wm;
  endfunction

  function automatic logic [GW-1:0] gen_vec(input int f, input int nreg);
    logic [GW-1:0] v;
    int w;
    v = '0;
    w = fw(f);
    for (int e = 0; e < nreg * VL / w; e++)
      v = v | (GW'(gen_el(w, few(f))) << (e * w));
    return v;
  endfunction

  task automatic apply(input logic [31:0] in, input bit fb, input bit fbf,
                       input logic [GW-1:0] d, input logic [VL-1:0] lo,
                       input logic [VL-1:0] hi, input string tag);
    int f, w, ew, nact;
    bit ok;
    logic [GW-1:0] er;
    logic [63:0] wm, de, le, he;
    bit einv;
    f  = int'(in[23:22]);
    w  = fw(f);
    ew = few(f);
    ok = (in[31:24] == 8'hC1) && in[21] && !in[0] &&
         ((in[15:10] == 6'b110000) || (in[15:10] == 6'b110010 && !in[1])) &&
         ((f == 0) ? fbf : fb);
    nact = (in[15:10] == 6'b110010) ? 4 : 2;
    wm = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    er = d;
    einv = 1'b0;
    if (ok) begin
      for (int r = 0; r < nact; r++)
        for (int e = 0; e < VL / w; e++) begin
          de = 64'(d >> (r * VL + e * w)) & wm;
          le = 64'(lo >> (e * w)) & wm;
          he = 64'(hi >> (e * w)) & wm;
          if (r_snan(de, w, ew) || r_snan(le, w, ew) || r_snan(he, w, ew)) einv = 1'b1;
          er = (er & ~(GW'(wm) << (r * VL + e * w))) |
               (GW'(r_min(r_max(de, le, w, ew), he, w, ew)) << (r * VL + e * w));
        end
    end
    @(negedge clk);
    insn = in; feat_base = fb; feat_bf16 = fbf;
    dst = d; lo_bnd = lo; hi_bnd = hi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R1 done"}, GW'(done), GW'(1));
    chk({tag, " R4 R5 R6 illegal"}, GW'(illegal), GW'(!ok));
    chk({tag, " R10 invalid"}, GW'(invalid), GW'(einv));
    chk({tag, " R2 R3 R7 R8 R9 R11 res"}, res, er);
    insn = ~insn; dst = ~dst;
    @(negedge clk);
    chk({tag, " R1 done drop"}, GW'(done), GW'(0));
    chk({tag, " R1 res hold"}, res, er);
  endtask

  function automatic logic [GW-1:0] rep(input logic [63:0] x, input int w, input int n);
    logic [GW-1:0] v;
    v = '0;
    for (int e = 0; e < n; e++) v = v | (GW'(x) << (e * w));
    return v;
  endfunction

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; insn = '0; feat_base = 1'b1; feat_bf16 = 1'b1;
    dst = '0; lo_bnd = '0; hi_bnd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset done", GW'(done), GW'(0));
    chk("R1 reset flags", GW'({illegal, invalid}), GW'(0));
    chk("R1 reset res", res, '0);

    // R2: lo above hi returns hi (single: d=1.0 lo=3.0 hi=2.0)
    apply(mk_insn(2, 0), 1, 1, rep(64'h3F800000, 32, 16), VL'(rep(64'h40400000, 32, 4)),
          VL'(rep(64'h40000000, 32, 4)), "R2 order");
    // R11: signed zeros, half
    apply(mk_insn(1, 1), 1, 0, rep(64'h0000, 16, 32), VL'(rep(64'h8000, 16, 8)),
          VL'(rep(64'h8000, 16, 8)), "R11 zeros a");
    apply(mk_insn(1, 0), 1, 0, rep(64'h8000, 16, 32), VL'(rep(64'h0000, 16, 8)),
          VL'(rep(64'h0000, 16, 8)), "R11 zeros b");
    // R9: all NaN with payload, double, gives default NaN
    apply(mk_insn(3, 1), 1, 0, rep(64'hFFF8000000000001, 64, 8),
          VL'(rep(64'h7FF8000000000005, 64, 2)), VL'(rep(64'hFFF0000000000001, 64, 2)), "R9 dnan");
    // R10: sNaN in bf16 dest
    apply(mk_insn(0, 0), 0, 1, rep(64'h7F81, 16, 32), VL'(rep(64'h3F80, 16, 8)),
          VL'(rep(64'h4000, 16, 8)), "R10 snan");
    // R7: sNaN only in reg 3 of a pair form
    apply(mk_insn(2, 0), 1, 1, {VL'(rep(64'h7F800001, 32, 4)), {(3*VL){1'b0}}},
          VL'(rep(64'hBF800000, 32, 4)), VL'(rep(64'h3F800000, 32, 4)), "R7 outside");
    // R5: feature gating
    apply(mk_insn(0, 1), 1, 0, gen_vec(0, 4), VL'(gen_vec(0, 1)), VL'(gen_vec(0, 1)), "R5 bf16 off");
    apply(mk_insn(1, 1), 0, 1, gen_vec(1, 4), VL'(gen_vec(1, 1)), VL'(gen_vec(1, 1)), "R5 base off");
    // R4: encoding checks
    apply(mk_insn(2, 0) | 32'h1, 1, 1, gen_vec(2, 4), VL'(gen_vec(2, 1)), VL'(gen_vec(2, 1)), "R4 bit0");
    apply(mk_insn(2, 1) | 32'h2, 1, 1, gen_vec(2, 4), VL'(gen_vec(2, 1)), VL'(gen_vec(2, 1)), "R4 quad bit1");
    apply(mk_insn(2, 0) | 32'h400, 1, 1, gen_vec(2, 4), VL'(gen_vec(2, 1)), VL'(gen_vec(2, 1)), "R4 opcode");
    apply(mk_insn(2, 0) & ~32'h0020_0000, 1, 1, gen_vec(2, 4), VL'(gen_vec(2, 1)), VL'(gen_vec(2, 1)), "R4 bit21");

    // random mix: R2 R3 R8 R9 R10 R11
    for (int k = 0; k < 300; k++) begin
      int f;
      logic [31:0] in;
      f  = int'($urandom % 4);
      in = mk_insn(f, bit'($urandom % 2));
      if ($urandom % 10 == 0) in = in ^ (32'd1 << ($urandom % 32));
      apply(in, ($urandom % 8) != 0, ($urandom % 5) != 0, gen_vec(f, 4),
            VL'(gen_vec(f, 1)), VL'(gen_vec(f, 1)), "rand R3 R8");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule